// File: doc/BRIEF.md
# Multislope Charge-Balance Sequencer

This block is the digital controller of a multislope integrating converter. A host asks for a conversion of N balancing periods over a valid/ready request port. The sequencer first switches off both reference currents and asks an external residue reader for a reading of the integrator. It then connects the input and runs N balancing periods of fixed length. At the start of each period it looks at the synchronized comparator and picks one of two duty levels. The short/long pair keeps the number of switch edges the same in every period, whatever the input.

After the last period the input is disconnected and the count of periods in which reference B held the long phase is published for one cycle. A second residue reading follows. Between conversions the block dithers: it steers whichever reference pushes the integrator back toward zero and re-evaluates at a fixed interval. It leaves dither as soon as a new request is taken.

Top module: `msadc_seq`

## Requirements
- R1: After reset the block is in dither: req_ready is 1, result_valid is 0, result_count is 0, res_start is 0 and sw_in is 0.
- R2: sw_a and sw_b are never 1 in the same cycle.
- R3: A balancing period lasts LONG_CLKS+SHORT_CLKS clocks (default 30+2). In its first clock sw_a is 1. If the synchronized comparator reads 1 there (cmp_in held stable from at least 3 clocks before), sw_a stays 1 for LONG_CLKS clocks and sw_b is 1 for the remaining SHORT_CLKS clocks.
- R4: If the synchronized comparator reads 0 at the first clock of a period, sw_a is 1 for SHORT_CLKS clocks and sw_b for LONG_CLKS clocks, and the result counter increases by one.
- R5: result_count equals the number of periods of R4 in the conversion. It appears with result_valid high for exactly one cycle, in the cycle following the end of period N, which is N*(LONG_CLKS+SHORT_CLKS) cycles after the first period began.
- R6: After a request is taken, both reference switches and sw_in are 0 and res_start stays 1 until res_done is seen. No period starts before that.
- R7: After the last period, both switches and sw_in are 0 and res_start stays 1 until res_done. The block then returns to dither with req_ready 1.
- R8: sw_in is 1 exactly during balancing periods.
- R9: In dither, sw_a follows a comparator reading of 1 and sw_b a reading of 0, refreshed every DITHER_CLKS clocks.
- R10: Requests are taken only while req_ready is 1 (in dither). A req_valid raised during a conversion has no effect on its result.
- R11: A request with N = 0 runs no period. It performs both residue handshakes and publishes a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | 1 | Asynchronous comparator, 1 = integrator high |
| req_valid | input | 1 | Host conversion request |
| req_count | input | CNT_W | Number of periods N |
| req_ready | output | 1 | Request can be taken (dither) |
| res_start | output | 1 | Residue reading requested, held until done |
| res_done | input | 1 | Residue reader finished |
| sw_a | output | 1 | Reference A steering switch |
| sw_b | output | 1 | Reference B steering switch |
| sw_in | output | 1 | Input connect switch |
| result_valid | output | 1 | One-cycle result strobe |
| result_count | output | CNT_W | Count of B-long periods |

## Verification
A request seen at an edge makes res_start visible in the next cycle. A res_done seen at an edge starts period 0 in the next cycle, or raises result_valid in the next cycle when N is 0. The strobe then follows exactly 32·N cycles after the first period cycle. The bench takes sw_in rising as cycle 0 and indexes every later sample from it. It changes the comparator only at the middle of a period, so each decision has a known value two synchronizer stages earlier. Dither outputs are checked only after two full refresh intervals plus the synchronizer delay.

// File: rtl/msadc_pkg.sv
// Shared types of the multislope sequencer.
package msadc_pkg;
    typedef enum logic [1:0] {
        ST_DITHER = 2'd0,
        ST_PRE    = 2'd1,
        ST_PWM    = 2'd2,
        ST_POST   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/msadc_sync.sv
// Two-flop synchronizer for the comparator.
// Assumes the input is asynchronous and slow compared with clk.
module msadc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic s1_q, s2_q;

    // shift the async level through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= d_async;
            s2_q <= s1_q;
        end
    end

    assign q_sync = s2_q;
endmodule

// File: rtl/msadc_pwm.sv
// Balancing engine: runs fixed-length periods with two duty levels and
// counts the periods in which reference B gets the long phase.
// Assumes load and go are never high together.
module msadc_pwm #(
    parameter int LONG_CLKS  = 30,
    parameter int SHORT_CLKS = 2,
    parameter int CNT_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] n_in,
    input  logic             go,
    input  logic             cmp_s,
    output logic             sw_a,
    output logic             sw_b,
    output logic             last,
    output logic             empty,
    output logic [CNT_W-1:0] bcount
);
    localparam int PERIOD = LONG_CLKS + SHORT_CLKS;
    localparam int PH_W   = $clog2(PERIOD);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(PERIOD - 1);
    localparam logic [PH_W:0]   LEN_LONG  = (PH_W + 1)'(LONG_CLKS);
    localparam logic [PH_W:0]   LEN_SHORT = (PH_W + 1)'(SHORT_CLKS);

    logic [PH_W-1:0]  ph_q;
    logic             dir_q;
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] cnt_q;
    logic             dir_now;
    logic [PH_W:0]    a_len;

    // decision is live in the first clock, held afterwards
    always_comb begin
        dir_now = (ph_q == '0) ? cmp_s : dir_q;
        a_len   = dir_now ? LEN_LONG : LEN_SHORT;
    end

    assign sw_a   = go && ({1'b0, ph_q} < a_len);
    assign sw_b   = go && !({1'b0, ph_q} < a_len);
    assign last   = go && (ph_q == PH_LAST) && (left_q == CNT_W'(1));
    assign empty  = (left_q == '0);
    assign bcount = cnt_q;

    // phase, direction, remaining periods and B-long count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            dir_q  <= 1'b0;
            left_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            ph_q   <= '0;
            left_q <= n_in;
            cnt_q  <= '0;
        end else if (go) begin
            if (ph_q == PH_LAST) begin
                ph_q   <= '0;
                left_q <= left_q - CNT_W'(1);
            end else begin
                ph_q <= ph_q + PH_W'(1);
            end
            if (ph_q == '0) begin
                dir_q <= cmp_s;
                if (!cmp_s) cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assert_phase_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !load && ph_q == PH_LAST) |=> (ph_q == '0));
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !load && ph_q == '0 && !cmp_s) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
    assert_a_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && ph_q == '0) |-> sw_a);
endmodule

// File: rtl/msadc_dither.sv
// Idle dither loop: steers the reference that drives the integrator
// back toward zero, refreshing its choice every DITHER_CLKS clocks.
module msadc_dither #(
    parameter int DITHER_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cmp_s,
    output logic sw_a,
    output logic sw_b
);
    localparam int DW = (DITHER_CLKS > 1) ? $clog2(DITHER_CLKS) : 1;
    localparam logic [DW-1:0] T_LAST = DW'(DITHER_CLKS - 1);

    logic [DW-1:0] tmr_q;
    logic          pol_q;

    // refresh timer and polarity latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
            pol_q <= 1'b0;
        end else if (en) begin
            if (tmr_q == T_LAST) begin
                tmr_q <= '0;
                pol_q <= cmp_s;
            end else begin
                tmr_q <= tmr_q + DW'(1);
            end
        end
    end

    assign sw_a = en && pol_q;
    assign sw_b = en && !pol_q;

    assert_dither_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && tmr_q != '0) |-> $stable(pol_q));
endmodule

// File: rtl/msadc_seq.sv
// Multislope sequencer top: request intake, residue handshakes,
// balancing periods and idle dither. Assumes res_done answers a held
// res_start, and that cmp_in is the raw integrator comparator.
module msadc_seq #(
    parameter int LONG_CLKS   = 30,
    parameter int SHORT_CLKS  = 2,
    parameter int CNT_W       = 32,
    parameter int DITHER_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_in,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] req_count,
    output logic             req_ready,
    output logic             res_start,
    input  logic             res_done,
    output logic             sw_a,
    output logic             sw_b,
    output logic             sw_in,
    output logic             result_valid,
    output logic [CNT_W-1:0] result_count
);
    import msadc_pkg::*;

    seq_state_t       st_q, st_d;
    logic             cmp_s;
    logic             load, pwm_go, pwm_last, pwm_empty;
    logic             pa, pb, da, db;
    logic [CNT_W-1:0] bcount;
    logic             pub;
    logic             rv_q;
    logic [CNT_W-1:0] rc_q;

    msadc_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_in),
        .q_sync  (cmp_s)
    );

    msadc_pwm #(
        .LONG_CLKS  (LONG_CLKS),
        .SHORT_CLKS (SHORT_CLKS),
        .CNT_W      (CNT_W)
    ) u_pwm (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .n_in   (req_count),
        .go     (pwm_go),
        .cmp_s  (cmp_s),
        .sw_a   (pa),
        .sw_b   (pb),
        .last   (pwm_last),
        .empty  (pwm_empty),
        .bcount (bcount)
    );

    msadc_dither #(
        .DITHER_CLKS (DITHER_CLKS)
    ) u_dith (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (st_q == ST_DITHER),
        .cmp_s (cmp_s),
        .sw_a  (da),
        .sw_b  (db)
    );

    assign req_ready = (st_q == ST_DITHER);
    assign load      = req_ready && req_valid;
    assign pwm_go    = (st_q == ST_PWM);

    // next-state selection and publish strobe
    always_comb begin
        st_d = st_q;
        pub  = 1'b0;
        unique case (st_q)
            ST_DITHER: if (req_valid) st_d = ST_PRE;
            ST_PRE: if (res_done) begin
                if (pwm_empty) begin
                    st_d = ST_POST;
                    pub  = 1'b1;
                end else begin
                    st_d = ST_PWM;
                end
            end
            ST_PWM: if (pwm_last) begin
                st_d = ST_POST;
                pub  = 1'b1;
            end
            ST_POST: if (res_done) st_d = ST_DITHER;
            default: st_d = ST_DITHER;
        endcase
    end

    // state and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_DITHER;
            rv_q <= 1'b0;
            rc_q <= '0;
        end else begin
            st_q <= st_d;
            rv_q <= pub;
            if (pub) rc_q <= bcount;
        end
    end

    assign res_start    = (st_q == ST_PRE) || (st_q == ST_POST);
    assign sw_a         = pa | da;
    assign sw_b         = pb | db;
    assign sw_in        = pwm_go;
    assign result_valid = rv_q;
    assign result_count = rc_q;

    assert_ab_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_a && sw_b));
    assert_in_not_reading_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_in |-> !res_start && !req_ready);
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    assert_start_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_start && !res_done) |=> res_start);
    assert_quiet_reading_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_start |-> !sw_a && !sw_b && !sw_in);
    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !res_start && !sw_in);
endmodule

// File: tb/sim_msadc_seq.sv
module sim_msadc_seq;
    localparam int LONG  = 30;
    localparam int SHORT = 2;
    localparam int PER   = LONG + SHORT;
    localparam int DCLK  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_in = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_count = '0;
    logic        req_ready, res_start, sw_a, sw_b, sw_in, result_valid;
    logic        res_done = 1'b0;
    logic [31:0] result_count;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    msadc_seq #(.LONG_CLKS(LONG), .SHORT_CLKS(SHORT), .CNT_W(32), .DITHER_CLKS(DCLK)) u0 (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .req_valid(req_valid),
        .req_count(req_count), .req_ready(req_ready), .res_start(res_start),
        .res_done(res_done), .sw_a(sw_a), .sw_b(sw_b), .sw_in(sw_in),
        .result_valid(result_valid), .result_count(result_count)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic handshake();
        @(negedge clk) res_done = 1'b1;
        @(negedge clk) res_done = 1'b0;
    endtask

    // one conversion; pattern bit p = comparator level for period p
    task automatic convert(input int n, input logic [63:0] pat, input bit poke);
        int zeros = 0;
        for (int p = 0; p < n; p++) if (!pat[p]) zeros++;
        cmp_in = pat[0];
        @(negedge clk) begin req_valid = 1'b1; req_count = 32'(n); end
        @(negedge clk) req_valid = 1'b0;
        // R6: reading phase, quiet switches, start held
        for (int k = 0; k < 3; k++) begin
            chk(res_start && !sw_a && !sw_b && !sw_in && !req_ready, "R6 pre-read", res_start, 1);
            @(negedge clk);
        end
        handshake();
        if (n == 0) begin
            // R11: no period, result right away
            chk(result_valid && result_count == 0 && !sw_in, "R11 zero-length", result_count, 0);
        end else begin
            for (int i = 0; i < PER * n; i++) begin
                int ph = i % PER;
                int p  = i / PER;
                bit ea = (ph < (pat[p] ? LONG : SHORT));
                if (!(sw_a == ea && sw_b == !ea && sw_in))
                    chk(1'b0, pat[p] ? "R3 A-long wave" : "R4 B-long wave", {sw_a, sw_b, sw_in}, {ea, !ea, 1'b1});
                if (ph == PER - 1) chk(1'b1, "R8 period", 0, 0);
                if (ph == PER / 2) cmp_in = (p + 1 < 64) ? pat[p + 1] : 1'b0;
                if (poke && ph == 5) req_valid = 1'b1;
                if (poke && ph == 9) begin
                    req_valid = 1'b0;
                    chk(!req_ready, "R10 busy", req_ready, 0);
                end
                @(negedge clk);
            end
            req_valid = 1'b0;
            chk(result_valid && result_count == 32'(zeros), "R5 result", result_count, zeros);
        end
        chk(!sw_in && res_start && !sw_a && !sw_b, "R8 input off after", sw_in, 0);
        @(negedge clk);
        chk(!result_valid, "R5 one-cycle strobe", result_valid, 0);
        chk(res_start && !req_ready, "R7 post-read held", res_start, 1);
        @(negedge clk);
        handshake();
        chk(req_ready && !res_start, "R7 back to dither", req_ready, 1);
    endtask

    initial begin
        #2000000;
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(req_ready && !result_valid && result_count == 0 && !res_start && !sw_in,
            "R1 reset", result_count, 0);
        // R9 dither follows comparator
        for (int lv = 0; lv < 2; lv++) begin
            cmp_in = 1'(lv);
            repeat (2 * DCLK + 4) @(negedge clk);
            chk(sw_a == 1'(lv) && sw_b == !1'(lv) && !sw_in, "R9 dither", sw_a, lv);
        end
        // R11 zero-length
        convert(0, 64'd0, 1'b0);
        // exhaustive sweep of small N
        for (int n = 1; n <= 3; n++)
            for (int v = 0; v < (1 << n); v++)
                convert(n, 64'(v), 1'b0);
        // long run with arithmetic pattern, and R10 poke during conversion
        begin
            logic [63:0] pat = '0;
            for (int p = 0; p < 40; p++) pat[p] = ((p * 7) % 3) == 0;
            convert(40, pat, 1'b1);
        end
        convert(5, 64'h1f, 1'b0);
        convert(5, 64'h00, 1'b0);
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule